// File: doc/BRIEF.md
# Multicore Interrupt Distributor

This block gathers interrupt requests and hands each one to a chosen subset of up to four CPU cores. There are three kinds of source. Software can raise an inter-processor interrupt and pick its destinations. Each core has its own timer line and its own watchdog line. A vector of level-sensitive shared hardware lines can be steered to any subset of cores through a per-line target mask. Every core sees a separate copy of each interrupt's state: inactive, pending or active. One core can therefore finish an interrupt while the same interrupt is still waiting or running on another core.

Each core has its own interface. It shows the most urgent pending interrupt that may pre-empt the work the core is doing now, and it takes an acknowledge strobe and an end-of-interrupt strobe. A small stack of running priorities per core lets interrupts nest: each end-of-interrupt brings back the priority that was running before. Enables and priorities for IDs below 32 are banked per core, so the urgency of an inter-processor interrupt is set by the receiving core. Enables, priorities and target masks for the shared lines are global. All of these are set through a simple write-only configuration port.

Top module: `irq_distributor`

## Requirements
- R1: After reset no core has a request, every running priority reads 16 (idle), and every acknowledge ID reads 1023.
- R2: ID map: IDs 0 to 15 are software interrupts, ID 29 is the core's timer line, ID 30 is the core's watchdog line, and shared line hw_irq[k] is ID 32+k.
- R3: Configuration writes use field code 0 for enable (data bit 0), 1 for priority (data[3:0]) and 2 for target mask (bit c selects core c, shared IDs only). A raised shared line becomes pending only on the cores whose bit is set in its mask.
- R4: A software request with mode 0 targets the cores set in sgi_targets, mode 1 targets every core except sgi_src, and mode 2 targets only sgi_src.
- R5: State is held per core. An acknowledge or end-of-interrupt on one core leaves the pending or active state of the same ID on other cores unchanged.
- R6: An acknowledge returns the presented ID on cpu_ack_id in the next cycle, moves that ID from pending to active on that core only, and removes the presentation in that cycle.
- R7: An acknowledge while nothing is presented returns 1023 and changes no state.
- R8: Among pending, enabled IDs the lowest priority value wins, and a tie goes to the lower ID. A disabled ID is never presented, but it stays pending and is presented once enabled.
- R9: A pending ID is presented only if its priority value is strictly below the core's running priority. After the acknowledge, the running priority becomes that ID's priority.
- R10: An end-of-interrupt naming an active ID makes it inactive and restores the previous running priority. One naming an ID that is not active on that core is ignored.
- R11: With four nested interrupts active on a core, nothing more is presented there until an end-of-interrupt frees a level.
- R12: A source becomes pending on a core only while the ID is inactive there. A level line still high after end-of-interrupt becomes pending again.
- R13: Enable and priority of IDs 0 to 31 are banked per core (selected by cfg_cpu). Shared IDs use one global setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 2 | 0 enable, 1 priority, 2 target mask |
| cfg_cpu | input | 2 | Bank select for IDs below 32 |
| cfg_id | input | 6 | Interrupt ID being configured |
| cfg_data | input | 4 | Write data |
| sgi_valid | input | 1 | Software interrupt request strobe |
| sgi_src | input | 2 | Requesting core |
| sgi_mode | input | 2 | 0 list, 1 all but requester, 2 requester only |
| sgi_targets | input | 4 | Core list for mode 0 |
| sgi_id | input | 4 | Software interrupt ID (0 to 15) |
| hw_irq | input | 32 | Shared level-sensitive lines, IDs 32 and up |
| timer_irq | input | 4 | Per-core timer lines (ID 29) |
| wdog_irq | input | 4 | Per-core watchdog lines (ID 30) |
| cpu_ack | input | 4 | Per-core acknowledge strobe |
| cpu_eoi | input | 4 | Per-core end-of-interrupt strobe |
| cpu_eoi_id | input | 40 | Per-core end-of-interrupt ID, 10 bits each |
| cpu_irq | output | 4 | Per-core interrupt request |
| cpu_irq_id | output | 40 | Per-core presented ID (1023 when none) |
| cpu_ack_id | output | 40 | Per-core ID returned by the last acknowledge |
| cpu_run_prio | output | 20 | Per-core running priority, 5 bits each, 16 idle |

## Verification
The same shared line is sent to two cores, and a different interrupt is sent to all four. Servicing one core while another still waits separates per-core state from global state. Three shared lines are given equal and unequal priorities, which separates value ordering from ID tie-breaking and from strict-less pre-emption. A nest of a shared line, a software interrupt and the timer shows whether the stack restores the right priority, and a four-deep nest shows whether presentation stops when the stack is full. Software requests are sent in each of the three destination modes, with one ID enabled in only one bank, to tell the modes and the banking apart.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam int SGI_NUM = 16;
  localparam int PRIV_NUM = 32;
  localparam int TIMER_ID = 29;
  localparam int WDOG_ID = 30;

  typedef enum logic [1:0] {
    SGI_LIST   = 2'd0,
    SGI_OTHERS = 2'd1,
    SGI_SELF   = 2'd2
  } sgi_mode_e;

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_PRIO   = 2'd1,
    CFG_TARGET = 2'd2
  } cfg_field_e;
endpackage

// File: rtl/irq_dist_cfg.sv
module irq_dist_cfg
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SPI = 32,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 4,
  localparam int NUM_ID = PRIV_NUM + NUM_SPI,
  localparam int IDX_W  = $clog2(NUM_ID),
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          cfg_we,
  input  logic [1:0]                                    cfg_field,
  input  logic [CPU_W-1:0]                              cfg_cpu,
  input  logic [IDX_W-1:0]                              cfg_id,
  input  logic [DATA_W-1:0]                             cfg_data,
  output logic [NUM_CPU-1:0][NUM_ID-1:0]                en_o,
  output logic [NUM_CPU-1:0][NUM_ID-1:0][PRIO_W-1:0]    prio_o,
  output logic [NUM_CPU-1:0][NUM_SPI-1:0]               tgt_o
);
  localparam int SPI_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;

  logic [NUM_CPU-1:0][PRIV_NUM-1:0]             priv_en_q;
  logic [NUM_CPU-1:0][PRIV_NUM-1:0][PRIO_W-1:0] priv_prio_q;
  logic [NUM_SPI-1:0]                           spi_en_q;
  logic [NUM_SPI-1:0][PRIO_W-1:0]               spi_prio_q;
  logic [NUM_CPU-1:0][NUM_SPI-1:0]              tgt_q;

  logic             is_priv, is_spi, cpu_ok;
  logic [IDX_W-1:0] spi_off;
  logic [SPI_W-1:0] spi_idx;
  logic [4:0]       priv_idx;

  always_comb begin
    is_priv  = 32'(cfg_id) < PRIV_NUM;
    is_spi   = !is_priv && (32'(cfg_id) < NUM_ID);
    cpu_ok   = 32'(cfg_cpu) < NUM_CPU;
    spi_off  = cfg_id - IDX_W'(PRIV_NUM);
    spi_idx  = spi_off[SPI_W-1:0];
    priv_idx = cfg_id[4:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_en_q   <= '0;
      priv_prio_q <= '0;
      spi_en_q    <= '0;
      spi_prio_q  <= '0;
      tgt_q       <= '0;
    end else if (cfg_we) begin
      if (is_priv && cpu_ok) begin
        case (cfg_field_e'(cfg_field))
          CFG_ENABLE: priv_en_q[cfg_cpu][priv_idx]   <= cfg_data[0];
          CFG_PRIO:   priv_prio_q[cfg_cpu][priv_idx] <= cfg_data[PRIO_W-1:0];
          default: ;
        endcase
      end else if (is_spi) begin
        case (cfg_field_e'(cfg_field))
          CFG_ENABLE: spi_en_q[spi_idx]   <= cfg_data[0];
          CFG_PRIO:   spi_prio_q[spi_idx] <= cfg_data[PRIO_W-1:0];
          CFG_TARGET: begin
            for (int c = 0; c < NUM_CPU; c++) tgt_q[c][spi_idx] <= cfg_data[c];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      en_o[c]   = {spi_en_q, priv_en_q[c]};
      prio_o[c] = {spi_prio_q, priv_prio_q[c]};
    end
    tgt_o = tgt_q;
  end
endmodule

// File: rtl/irq_dist_sgi.sv
module irq_dist_sgi
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               valid_i,
  input  logic [CPU_W-1:0]   src_i,
  input  logic [1:0]         mode_i,
  input  logic [NUM_CPU-1:0] list_i,
  input  logic [3:0]         id_i,
  output logic [NUM_CPU-1:0] dest_o,
  output logic [SGI_NUM-1:0] id_hot_o
);
  logic [NUM_CPU-1:0] self_mask;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) self_mask[c] = (32'(src_i) == c);
    dest_o = '0;
    if (valid_i) begin
      case (sgi_mode_e'(mode_i))
        SGI_LIST:   dest_o = list_i;
        SGI_OTHERS: dest_o = ~self_mask;
        SGI_SELF:   dest_o = self_mask;
        default:    dest_o = '0;
      endcase
    end
    id_hot_o = valid_i ? (SGI_NUM'(1) << id_i) : '0;
  end
endmodule

// File: rtl/irq_dist_cpu.sv
module irq_dist_cpu
  import irq_dist_pkg::*;
#(
  parameter int NUM_ID = 64,
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(NUM_ID),
  localparam int DEP_W = $clog2(DEPTH + 1),
  localparam int RP_W  = PRIO_W + 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_ID-1:0]              set_i,
  input  logic [NUM_ID-1:0]              en_i,
  input  logic [NUM_ID-1:0][PRIO_W-1:0]  prio_i,
  input  logic                           ack_i,
  input  logic                           eoi_i,
  input  logic [ID_W-1:0]                eoi_id_i,
  output logic                           irq_o,
  output logic [ID_W-1:0]                irq_id_o,
  output logic [ID_W-1:0]                ack_id_o,
  output logic [RP_W-1:0]                run_prio_o
);
  localparam logic [RP_W-1:0] IDLE_PRIO = RP_W'(1) << PRIO_W;

  logic [NUM_ID-1:0]             pend_q, act_q;
  logic [DEPTH-1:0][PRIO_W-1:0]  stk_q;
  logic [DEP_W-1:0]              dep_q;
  logic                          pres_v_q;
  logic [IDX_W-1:0]              pres_idx_q;
  logic [ID_W-1:0]               ack_id_q;

  logic [RP_W-1:0]   run_prio;
  logic              best_vld, take, full;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_p;

  // running priority from the top of the stack
  always_comb begin
    run_prio = IDLE_PRIO;
    for (int i = 0; i < DEPTH; i++)
      if (32'(dep_q) == i + 1) run_prio = {1'b0, stk_q[i]};
  end

  // lowest value wins, scan order keeps the lower ID on ties
  always_comb begin
    best_vld = 1'b0;
    best_idx = '0;
    best_p   = '1;
    for (int i = 0; i < NUM_ID; i++) begin
      if (pend_q[i] && en_i[i] && !act_q[i] && (!best_vld || prio_i[i] < best_p)) begin
        best_vld = 1'b1;
        best_idx = IDX_W'(i);
        best_p   = prio_i[i];
      end
    end
    full = 32'(dep_q) >= DEPTH;
    take = best_vld && ({1'b0, best_p} < run_prio) && !full;
  end

  logic              ack_hit, eoi_hit;
  logic [NUM_ID-1:0] ack_mask, eoi_mask;
  logic [DEP_W-1:0]  pop_dep;

  always_comb begin
    ack_hit  = ack_i && pres_v_q;
    eoi_hit  = eoi_i && (32'(eoi_id_i) < NUM_ID) && act_q[eoi_id_i[IDX_W-1:0]];
    ack_mask = ack_hit ? (NUM_ID'(1) << pres_idx_q) : '0;
    eoi_mask = eoi_hit ? (NUM_ID'(1) << eoi_id_i[IDX_W-1:0]) : '0;
    pop_dep  = dep_q - DEP_W'(eoi_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      act_q      <= '0;
      stk_q      <= '0;
      dep_q      <= '0;
      pres_v_q   <= 1'b0;
      pres_idx_q <= '0;
      ack_id_q   <= SPURIOUS_ID;
    end else begin
      pend_q <= (pend_q | (set_i & ~act_q)) & ~ack_mask;
      act_q  <= (act_q | ack_mask) & ~eoi_mask;
      if (ack_hit) begin
        for (int i = 0; i < DEPTH; i++)
          if (32'(pop_dep) == i) stk_q[i] <= prio_i[pres_idx_q];
      end
      dep_q <= pop_dep + DEP_W'(ack_hit);
      if (ack_i)
        ack_id_q <= ack_hit ? ID_W'(pres_idx_q) : SPURIOUS_ID;
      pres_v_q   <= (ack_i || eoi_i) ? 1'b0 : take;
      pres_idx_q <= best_idx;
    end
  end

  assign irq_o      = pres_v_q;
  assign irq_id_o   = pres_v_q ? ID_W'(pres_idx_q) : SPURIOUS_ID;
  assign ack_id_o   = ack_id_q;
  assign run_prio_o = run_prio;
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPU     = 4,
  parameter int NUM_SPI     = 32,
  parameter int PRIO_W      = 4,
  parameter int STACK_DEPTH = 4,
  localparam int NUM_ID = PRIV_NUM + NUM_SPI,
  localparam int IDX_W  = $clog2(NUM_ID),
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int DATA_W = (PRIO_W > NUM_CPU) ? PRIO_W : NUM_CPU,
  localparam int RP_W   = PRIO_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_field,
  input  logic [CPU_W-1:0]          cfg_cpu,
  input  logic [IDX_W-1:0]          cfg_id,
  input  logic [DATA_W-1:0]         cfg_data,
  input  logic                      sgi_valid,
  input  logic [CPU_W-1:0]          sgi_src,
  input  logic [1:0]                sgi_mode,
  input  logic [NUM_CPU-1:0]        sgi_targets,
  input  logic [3:0]                sgi_id,
  input  logic [NUM_SPI-1:0]        hw_irq,
  input  logic [NUM_CPU-1:0]        timer_irq,
  input  logic [NUM_CPU-1:0]        wdog_irq,
  input  logic [NUM_CPU-1:0]        cpu_ack,
  input  logic [NUM_CPU-1:0]        cpu_eoi,
  input  logic [NUM_CPU*ID_W-1:0]   cpu_eoi_id,
  output logic [NUM_CPU-1:0]        cpu_irq,
  output logic [NUM_CPU*ID_W-1:0]   cpu_irq_id,
  output logic [NUM_CPU*ID_W-1:0]   cpu_ack_id,
  output logic [NUM_CPU*RP_W-1:0]   cpu_run_prio
);
  logic [NUM_CPU-1:0][NUM_ID-1:0]             en_w;
  logic [NUM_CPU-1:0][NUM_ID-1:0][PRIO_W-1:0] prio_w;
  logic [NUM_CPU-1:0][NUM_SPI-1:0]            tgt_w;
  logic [NUM_CPU-1:0]                         sgi_dest;
  logic [SGI_NUM-1:0]                         sgi_hot;

  irq_dist_cfg #(
    .NUM_CPU(NUM_CPU), .NUM_SPI(NUM_SPI), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .cfg_cpu(cfg_cpu), .cfg_id(cfg_id), .cfg_data(cfg_data),
    .en_o(en_w), .prio_o(prio_w), .tgt_o(tgt_w)
  );

  irq_dist_sgi #(.NUM_CPU(NUM_CPU)) u_sgi (
    .valid_i(sgi_valid), .src_i(sgi_src), .mode_i(sgi_mode),
    .list_i(sgi_targets), .id_i(sgi_id),
    .dest_o(sgi_dest), .id_hot_o(sgi_hot)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_ID-1:0] set_vec;

    always_comb begin
      set_vec = '0;
      if (sgi_dest[c]) set_vec[SGI_NUM-1:0] = sgi_hot;
      set_vec[TIMER_ID] = timer_irq[c];
      set_vec[WDOG_ID]  = wdog_irq[c];
      set_vec[NUM_ID-1:PRIV_NUM] = hw_irq & tgt_w[c];
    end

    irq_dist_cpu #(
      .NUM_ID(NUM_ID), .PRIO_W(PRIO_W), .DEPTH(STACK_DEPTH)
    ) u_cpu (
      .clk(clk), .rst(rst),
      .set_i(set_vec), .en_i(en_w[c]), .prio_i(prio_w[c]),
      .ack_i(cpu_ack[c]), .eoi_i(cpu_eoi[c]),
      .eoi_id_i(cpu_eoi_id[c*ID_W +: ID_W]),
      .irq_o(cpu_irq[c]),
      .irq_id_o(cpu_irq_id[c*ID_W +: ID_W]),
      .ack_id_o(cpu_ack_id[c*ID_W +: ID_W]),
      .run_prio_o(cpu_run_prio[c*RP_W +: RP_W])
    );
  end
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SPI = 32,
  parameter int PRIO_W  = 4,
  localparam int RP_W   = PRIO_W + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CPU-1:0]      cpu_ack,
  input logic [NUM_CPU-1:0]      cpu_irq,
  input logic [NUM_CPU*ID_W-1:0] cpu_irq_id,
  input logic [NUM_CPU*ID_W-1:0] cpu_ack_id,
  input logic [NUM_CPU*RP_W-1:0] cpu_run_prio
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    assert_spurious_ack_R7: assert property (@(posedge clk) disable iff (rst)
      (cpu_ack[c] && !cpu_irq[c]) |=> cpu_ack_id[c*ID_W +: ID_W] == SPURIOUS_ID);

    assert_ack_returns_id_R6: assert property (@(posedge clk) disable iff (rst)
      (cpu_ack[c] && cpu_irq[c]) |=>
        cpu_ack_id[c*ID_W +: ID_W] == $past(cpu_irq_id[c*ID_W +: ID_W]));

    assert_ack_drops_request_R6: assert property (@(posedge clk) disable iff (rst)
      cpu_ack[c] |=> !cpu_irq[c]);

    assert_ack_raises_priority_R9: assert property (@(posedge clk) disable iff (rst)
      (cpu_ack[c] && cpu_irq[c]) |=>
        cpu_run_prio[c*RP_W +: RP_W] < $past(cpu_run_prio[c*RP_W +: RP_W]));

    assert_valid_id_R2: assert property (@(posedge clk) disable iff (rst)
      cpu_irq[c] |-> (32'(cpu_irq_id[c*ID_W +: ID_W]) < PRIV_NUM + NUM_SPI));
  end
endmodule

bind irq_distributor irq_distributor_chk #(
  .NUM_CPU(NUM_CPU), .NUM_SPI(NUM_SPI), .PRIO_W(PRIO_W)
) u_chk (
  .clk(clk), .rst(rst), .cpu_ack(cpu_ack), .cpu_irq(cpu_irq),
  .cpu_irq_id(cpu_irq_id), .cpu_ack_id(cpu_ack_id), .cpu_run_prio(cpu_run_prio)
);

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int IW = 10;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_field = '0;
  logic [1:0] cfg_cpu = '0;
  logic [5:0] cfg_id = '0;
  logic [3:0] cfg_data = '0;
  logic sgi_valid = 1'b0;
  logic [1:0] sgi_src = '0;
  logic [1:0] sgi_mode = '0;
  logic [3:0] sgi_targets = '0;
  logic [3:0] sgi_id = '0;
  logic [31:0] hw_irq = '0;
  logic [3:0] timer_irq = '0;
  logic [3:0] wdog_irq = '0;
  logic [3:0] cpu_ack = '0;
  logic [3:0] cpu_eoi = '0;
  logic [NC*IW-1:0] cpu_eoi_id = '0;
  logic [3:0] cpu_irq;
  logic [NC*IW-1:0] cpu_irq_id;
  logic [NC*IW-1:0] cpu_ack_id;
  logic [NC*RW-1:0] cpu_run_prio;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_distributor uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .cfg_cpu(cfg_cpu), .cfg_id(cfg_id), .cfg_data(cfg_data),
    .sgi_valid(sgi_valid), .sgi_src(sgi_src), .sgi_mode(sgi_mode),
    .sgi_targets(sgi_targets), .sgi_id(sgi_id), .hw_irq(hw_irq),
    .timer_irq(timer_irq), .wdog_irq(wdog_irq), .cpu_ack(cpu_ack),
    .cpu_eoi(cpu_eoi), .cpu_eoi_id(cpu_eoi_id), .cpu_irq(cpu_irq),
    .cpu_irq_id(cpu_irq_id), .cpu_ack_id(cpu_ack_id), .cpu_run_prio(cpu_run_prio)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int req(input int c);
    return int'(cpu_irq[c]);
  endfunction
  function automatic int pid(input int c);
    return int'(cpu_irq_id[c*IW +: IW]);
  endfunction
  function automatic int aid(input int c);
    return int'(cpu_ack_id[c*IW +: IW]);
  endfunction
  function automatic int rprio(input int c);
    return int'(cpu_run_prio[c*RW +: RW]);
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(input int field, input int cpu, input int id, input int data);
    cfg_we = 1'b1; cfg_field = 2'(field); cfg_cpu = 2'(cpu);
    cfg_id = 6'(id); cfg_data = 4'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic shared(input int id, input int prio, input int tgt, input int en);
    cfg(2, 0, id, tgt);
    cfg(1, 0, id, prio);
    cfg(0, 0, id, en);
  endtask

  task automatic sgi(input int src, input int mode, input int list, input int id);
    sgi_valid = 1'b1; sgi_src = 2'(src); sgi_mode = 2'(mode);
    sgi_targets = 4'(list); sgi_id = 4'(id);
    @(negedge clk);
    sgi_valid = 1'b0;
  endtask

  task automatic do_ack(input int c, output int id);
    cpu_ack[c] = 1'b1;
    @(negedge clk);
    cpu_ack[c] = 1'b0;
    id = aid(c);
  endtask

  task automatic do_eoi(input int c, input int id);
    cpu_eoi[c] = 1'b1;
    cpu_eoi_id[c*IW +: IW] = IW'(id);
    @(negedge clk);
    cpu_eoi[c] = 1'b0;
  endtask

  task automatic service(input int c, input int exp, input string tag);
    int got;
    do_ack(c, got);
    check(tag, got, exp);
    do_eoi(c, exp);
    settle();
  endtask

  task automatic t_reset();
    int got;
    for (int c = 0; c < NC; c++) begin
      check("R1 no request after reset", req(c), 0);
      check("R1 idle running priority", rprio(c), 16);
      check("R1 ack id reset", aid(c), 1023);
    end
    do_ack(0, got);
    check("R7 spurious ack after reset", got, 1023);
  endtask

  task automatic t_route();
    shared(40, 5, 4'b0110, 1);
    hw_irq[8] = 1'b1;
    settle();
    check("R3 cpu0 not targeted", req(0), 0);
    check("R3 cpu1 request", req(1), 1);
    check("R2 cpu1 id of line 8", pid(1), 40);
    check("R3 cpu2 id", pid(2), 40);
    check("R3 cpu3 not targeted", req(3), 0);
  endtask

  task automatic t_per_cpu();
    int got;
    do_ack(1, got);
    check("R6 ack returns id", got, 40);
    check("R6 presentation removed", req(1), 0);
    check("R5 cpu2 still presents", pid(2), 40);
    @(negedge clk);
    check("R9 running priority after ack", rprio(1), 5);
    check("R5 cpu2 running idle", rprio(2), 16);
    do_eoi(1, 40);
    settle();
    check("R10 priority restored", rprio(1), 16);
    check("R12 level line re-pends", pid(1), 40);
    hw_irq[8] = 1'b0;
    service(1, 40, "R5 cpu1 second service");
    service(2, 40, "R5 cpu2 service");
    check("R12 no re-pend after line low", req(1), 0);
    check("R5 cpu2 done", req(2), 0);
  endtask

  task automatic t_spurious();
    int got;
    do_ack(3, got);
    check("R7 spurious id", got, 1023);
    @(negedge clk);
    check("R7 no state change", rprio(3), 16);
  endtask

  task automatic t_mask();
    shared(41, 7, 4'b1111, 0);
    hw_irq[9] = 1'b1;
    settle();
    hw_irq[9] = 1'b0;
    settle();
    for (int c = 0; c < NC; c++) check("R8 disabled not presented", req(c), 0);
    cfg(0, 0, 41, 1);
    settle();
    for (int c = 0; c < NC; c++) check("R8 latched pending shown once enabled", pid(c), 41);
    for (int c = 0; c < NC; c++) service(c, 41, "R8 service masked id");
  endtask

  task automatic t_prio();
    int got;
    shared(33, 3, 4'b0001, 1);
    shared(34, 3, 4'b0001, 1);
    shared(35, 2, 4'b0001, 1);
    hw_irq[3:1] = 3'b111;
    @(negedge clk);
    hw_irq[3:1] = 3'b000;
    settle();
    check("R8 lowest value wins", pid(0), 35);
    do_ack(0, got);
    settle();
    check("R9 no pre-emption by lower urgency", req(0), 0);
    check("R9 running priority 2", rprio(0), 2);
    do_eoi(0, 35);
    settle();
    check("R8 tie goes to lower id", pid(0), 33);
    service(0, 33, "R8 service 33");
    check("R8 remaining id", pid(0), 34);
    do_ack(0, got);
    settle();
    check("R9 equal priority not presented", req(0), 0);
    do_eoi(0, 34);
    settle();
  endtask

  task automatic t_nest();
    int got;
    shared(50, 8, 4'b1000, 1);
    hw_irq[18] = 1'b1;
    @(negedge clk);
    hw_irq[18] = 1'b0;
    settle();
    check("R2 line 18 is id 50", pid(3), 50);
    do_ack(3, got);
    cfg(1, 3, 3, 4);
    cfg(0, 3, 3, 1);
    sgi(0, 0, 4'b1000, 3);
    settle();
    check("R9 pre-emption by software id", pid(3), 3);
    do_ack(3, got);
    check("R6 ack software id", got, 3);
    cfg(1, 3, 29, 1);
    cfg(0, 3, 29, 1);
    timer_irq[3] = 1'b1;
    @(negedge clk);
    timer_irq[3] = 1'b0;
    settle();
    check("R2 timer id", pid(3), 29);
    do_ack(3, got);
    @(negedge clk);
    check("R9 running priority 1", rprio(3), 1);
    do_eoi(3, 29);
    @(negedge clk);
    check("R10 restore to 4", rprio(3), 4);
    do_eoi(3, 3);
    @(negedge clk);
    check("R10 restore to 8", rprio(3), 8);
    do_eoi(3, 45);
    @(negedge clk);
    check("R10 eoi of inactive id ignored", rprio(3), 8);
    do_eoi(3, 50);
    @(negedge clk);
    check("R10 restore to idle", rprio(3), 16);
  endtask

  task automatic t_sgi();
    for (int c = 0; c < NC; c++) begin
      cfg(1, c, 5, 6);
      cfg(0, c, 5, 1);
    end
    sgi(1, 1, 4'b0000, 5);
    settle();
    check("R4 others mode cpu0", pid(0), 5);
    check("R4 others mode excludes requester", req(1), 0);
    check("R4 others mode cpu2", pid(2), 5);
    check("R4 others mode cpu3", pid(3), 5);
    service(0, 5, "R4 svc0");
    service(2, 5, "R4 svc2");
    service(3, 5, "R4 svc3");
    sgi(2, 2, 4'b1111, 5);
    settle();
    check("R4 self mode requester", pid(2), 5);
    check("R4 self mode cpu0 untouched", req(0), 0);
    service(2, 5, "R4 svc self");
    sgi(0, 0, 4'b1001, 5);
    settle();
    check("R4 list mode cpu0", pid(0), 5);
    check("R4 list mode cpu1 excluded", req(1), 0);
    check("R4 list mode cpu3", pid(3), 5);
    service(0, 5, "R4 svc list0");
    service(3, 5, "R4 svc list3");
    cfg(1, 0, 6, 6);
    cfg(0, 0, 6, 1);
    sgi(0, 0, 4'b0011, 6);
    settle();
    check("R13 banked enable cpu0", pid(0), 6);
    check("R13 banked disable cpu1", req(1), 0);
    service(0, 6, "R13 svc");
  endtask

  task automatic t_depth();
    int got;
    int ids[4] = '{8, 9, 10, 11};
    int prs[4] = '{12, 10, 8, 6};
    for (int i = 0; i < 4; i++) begin
      cfg(1, 0, ids[i], prs[i]);
      cfg(0, 0, ids[i], 1);
    end
    cfg(1, 0, 12, 2);
    cfg(0, 0, 12, 1);
    for (int i = 0; i < 4; i++) begin
      sgi(0, 2, 4'b0000, ids[i]);
      settle();
      do_ack(0, got);
      check("R11 nest level ack", got, ids[i]);
    end
    @(negedge clk);
    check("R11 running priority at depth 4", rprio(0), 6);
    sgi(0, 2, 4'b0000, 12);
    settle();
    check("R11 full stack blocks presentation", req(0), 0);
    do_eoi(0, 11);
    settle();
    check("R11 presented after level freed", pid(0), 12);
    check("R10 running priority 8", rprio(0), 8);
    service(0, 12, "R11 svc 12");
    do_eoi(0, 10);
    do_eoi(0, 9);
    do_eoi(0, 8);
    @(negedge clk);
    check("R10 unwound to idle", rprio(0), 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_route();
    t_per_cpu();
    t_spurious();
    t_mask();
    t_prio();
    t_nest();
    t_sgi();
    t_depth();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule